// File: doc/BRIEF.md
# CAN Error Counter and Fault-Confinement Tracker

This block keeps a CAN node's transmit and receive error counters and works out the node's fault-confinement state from them. A bit-stream engine sends it single-cycle strobes: an error was detected (with a 3-bit error kind and a direction bit), a frame was sent cleanly, or a frame was received cleanly. The block updates the counters on the clock edge that samples a strobe. The counters, the warning flags, the error-passive and bus-off bits, and a capture of the last accepted error go to a register interface.

Two pulse outputs go to an interrupt block. One fires when the combined warning status changes. The other fires on every entry into error-passive and on every exit from it. A hold input stands for the controller's configuration mode. While hold is high, bus events are ignored and software may load both counters. A recovery request clears both counters and is the only way to leave bus-off.

Top module: `can_fault_tracker`

## Requirements
- R1: A transmit-direction error (ev_err with ev_err_rx=0) adds 8 to tec. If that sum would exceed 255, tec becomes 255 and bus_off is set on the same edge.
- R2: A receive-direction error (ev_err with ev_err_rx=1) adds 1 to rec, saturating at 255.
- R3: ev_tx_ok subtracts 1 from tec and ev_rx_ok subtracts 1 from rec. Neither counter goes below 0. An error in the same direction in the same cycle wins over the success strobe.
- R4: tx_warn is high when tec >= 96 and rx_warn is high when rec >= 96. warn_any is their OR.
- R5: err_passive is high when tec > 127 or rec > 127.
- R6: warn_evt is high for exactly the one cycle after each edge on which warn_any changes value, in either direction.
- R7: passive_evt is high for exactly the one cycle after each edge on which err_passive changes value, in either direction.
- R8: Each accepted error loads err_flags and err_dir, and both keep that value until the next accepted error. err_flags is one-hot: kind 0 sets bit 0 (bit error), 1 sets bit 1 (stuff), 2 sets bit 2 (CRC), 3 sets bit 3 (form), 4 sets bit 4 (acknowledge), and kinds 5 to 7 give all zeros. err_dir is 0 for transmit and 1 for receive.
- R9: While bus_off is high, all event strobes are ignored: the counters, err_flags and err_dir do not change. recover_req clears both counters and bus_off on the next edge, and it takes priority over every other input.
- R10: While hold_mode is high, event strobes are ignored. If load_en is also high, tec takes load_tec and rec takes load_rec.
- R11: After reset, the counters, flags, capture and pulses are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_mode | input | 1 | Configuration hold: events ignored |
| load_en | input | 1 | Load counters while in hold |
| load_tec | input | 8 | Value for tec on load |
| load_rec | input | 8 | Value for rec on load |
| recover_req | input | 1 | Clear both counters and leave bus-off |
| ev_err | input | 1 | Error detected strobe |
| ev_err_kind | input | 3 | Error kind code 0..4 |
| ev_err_rx | input | 1 | Error direction: 0 transmit, 1 receive |
| ev_tx_ok | input | 1 | Successful transmit strobe |
| ev_rx_ok | input | 1 | Successful receive strobe |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| tx_warn | output | 1 | tec at or above warning limit |
| rx_warn | output | 1 | rec at or above warning limit |
| warn_any | output | 1 | Either warning flag |
| err_passive | output | 1 | Error-passive state |
| bus_off | output | 1 | Bus-off state |
| err_flags | output | 5 | One-hot kind of last accepted error |
| err_dir | output | 1 | Direction of last accepted error |
| warn_evt | output | 1 | Warning status change pulse |
| passive_evt | output | 1 | Passive entry/exit pulse |

## Verification
The hardest situations to reach from the ports are the receive side crossing into error-passive and the exit from bus-off. Receive errors add only 1 per event, so an unbiased mix of strobes keeps rec near zero. Bus-off, once entered, swallows every strobe. The random stimulus therefore runs in phases with different biases: one favours transmit errors and one favours receive errors. Occasional hold-mode loads place the counters near the thresholds, and rare recovery requests bring the node back out of bus-off. Directed sequences cover zero floors, out-of-range kind codes, saturation and events ignored while in bus-off.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int KINDS = 5;

  typedef enum logic [2:0] {
    K_BIT   = 3'd0,
    K_STUFF = 3'd1,
    K_CRC   = 3'd2,
    K_FORM  = 3'd3,
    K_ACK   = 3'd4
  } err_kind_e;

  // One-hot flag vector for an error kind; codes beyond the last kind give zero.
  function automatic logic [KINDS-1:0] kind_to_flags(input logic [2:0] kind);
    logic [KINDS-1:0] f;
    f = '0;
    for (int i = 0; i < KINDS; i++)
      if (kind == 3'(i)) f[i] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/can_flt_counter.sv
module can_flt_counter #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV  = '1;
  localparam logic [W-1:0] STEPV = W'(STEP);

  function automatic logic [W-1:0] bump_up(input logic [W-1:0] v);
    return (v > MAXV - STEPV) ? MAXV : v + STEPV;
  endfunction

  function automatic logic [W-1:0] bump_down(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (up)   cnt <= bump_up(cnt);
    else if (down) cnt <= bump_down(cnt);
  end
endmodule

// File: rtl/can_flt_state.sv
module can_flt_state #(
  parameter int W           = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tec,
  input  logic [W-1:0] rec,
  output logic         tx_warn,
  output logic         rx_warn,
  output logic         warn_any,
  output logic         passive,
  output logic         warn_evt,
  output logic         passive_evt
);
  localparam logic [W-1:0] WARNV = W'(WARN_LIM);
  localparam logic [W-1:0] PASSV = W'(PASSIVE_LIM);

  logic warn_q, passive_q;

  assign tx_warn  = (tec >= WARNV);
  assign rx_warn  = (rec >= WARNV);
  assign warn_any = tx_warn | rx_warn;
  assign passive  = (tec > PASSV) | (rec > PASSV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q    <= 1'b0;
      passive_q <= 1'b0;
    end else begin
      warn_q    <= warn_any;
      passive_q <= passive;
    end
  end

  assign warn_evt    = warn_any ^ warn_q;
  assign passive_evt = passive ^ passive_q;
endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import can_flt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 127,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_mode,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_tec,
  input  logic [CNT_W-1:0] load_rec,
  input  logic             recover_req,
  input  logic             ev_err,
  input  logic [2:0]       ev_err_kind,
  input  logic             ev_err_rx,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             tx_warn,
  output logic             rx_warn,
  output logic             warn_any,
  output logic             err_passive,
  output logic             bus_off,
  output logic [KINDS-1:0] err_flags,
  output logic             err_dir,
  output logic             warn_evt,
  output logic             passive_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TX_TRIP = CNT_MAX - CNT_W'(TX_STEP);

  // Named internal events, also observed by the checker.
  logic accept, err_take, tx_inc, rx_inc, tx_dec, rx_dec, do_load, tx_trip;

  assign accept   = !hold_mode && !bus_off;
  assign err_take = accept && ev_err;
  assign tx_inc   = err_take && !ev_err_rx;
  assign rx_inc   = err_take &&  ev_err_rx;
  assign tx_dec   = accept && ev_tx_ok && !tx_inc;
  assign rx_dec   = accept && ev_rx_ok && !rx_inc;
  assign do_load  = hold_mode && load_en;
  assign tx_trip  = tx_inc && (tec > TX_TRIP);

  logic             up_v  [2];
  logic             dn_v  [2];
  logic [CNT_W-1:0] ld_v  [2];
  logic [CNT_W-1:0] cnt_v [2];

  assign up_v[0] = tx_inc;
  assign dn_v[0] = tx_dec;
  assign ld_v[0] = load_tec;
  assign up_v[1] = rx_inc;
  assign dn_v[1] = rx_dec;
  assign ld_v[1] = load_rec;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    can_flt_counter #(
      .W    (CNT_W),
      .STEP ((d == 0) ? TX_STEP : RX_STEP)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (recover_req),
      .load     (do_load),
      .load_val (ld_v[d]),
      .up       (up_v[d]),
      .down     (dn_v[d]),
      .cnt      (cnt_v[d])
    );
  end

  assign tec = cnt_v[0];
  assign rec = cnt_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bus_off <= 1'b0;
    else if (recover_req) bus_off <= 1'b0;
    else if (tx_trip)     bus_off <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_dir   <= 1'b0;
    end else if (err_take) begin
      err_flags <= kind_to_flags(ev_err_kind);
      err_dir   <= ev_err_rx;
    end
  end

  can_flt_state #(
    .W           (CNT_W),
    .WARN_LIM    (WARN_LIM),
    .PASSIVE_LIM (PASSIVE_LIM)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .tec         (tec),
    .rec         (rec),
    .tx_warn     (tx_warn),
    .rx_warn     (rx_warn),
    .warn_any    (warn_any),
    .passive     (err_passive),
    .warn_evt    (warn_evt),
    .passive_evt (passive_evt)
  );
endmodule

// File: rtl/can_fault_tracker_chk.sv
module can_fault_tracker_chk #(
  parameter int CNT_W   = 8,
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_mode,
  input logic             load_en,
  input logic             recover_req,
  input logic             tx_inc,
  input logic             rx_inc,
  input logic             tx_dec,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             bus_off,
  input logic             warn_any,
  input logic             err_passive,
  input logic             warn_evt,
  input logic             passive_evt,
  input logic [4:0]       err_flags,
  input logic             err_dir
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] TSV  = CNT_W'(TX_STEP);
  localparam logic [CNT_W-1:0] RSV  = CNT_W'(RX_STEP);

  p_tx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inc && !recover_req |=>
      (tec == (($past(tec) > MAXV - TSV) ? MAXV : $past(tec) + TSV)));

  p_enter_busoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inc && !recover_req && (tec > MAXV - TSV) |=> bus_off);

  p_rx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_inc && !recover_req |=>
      (rec == (($past(rec) > MAXV - RSV) ? MAXV : $past(rec) + RSV)));

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dec && (tec == '0) && !recover_req |=> (tec == '0));

  p_warn_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |-> (warn_any != $past(warn_any)));

  p_passive_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    passive_evt |-> (err_passive != $past(err_passive)));

  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_flags));

  p_busoff_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off && !recover_req && !(hold_mode && load_en) |=>
      ($stable(tec) && $stable(rec) && $stable(err_flags) && $stable(err_dir)));

  p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |=> (tec == '0) && (rec == '0) && !bus_off);
endmodule

bind can_fault_tracker can_fault_tracker_chk #(
  .CNT_W   (CNT_W),
  .TX_STEP (TX_STEP),
  .RX_STEP (RX_STEP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_mode   (hold_mode),
  .load_en     (load_en),
  .recover_req (recover_req),
  .tx_inc      (tx_inc),
  .rx_inc      (rx_inc),
  .tx_dec      (tx_dec),
  .tec         (tec),
  .rec         (rec),
  .bus_off     (bus_off),
  .warn_any    (warn_any),
  .err_passive (err_passive),
  .warn_evt    (warn_evt),
  .passive_evt (passive_evt),
  .err_flags   (err_flags),
  .err_dir     (err_dir)
);

// File: tb/test_can_fault_tracker.sv
module test_can_fault_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_mode = 0, load_en = 0, recover_req = 0;
  logic [7:0] load_tec = 0, load_rec = 0;
  logic       ev_err = 0, ev_err_rx = 0, ev_tx_ok = 0, ev_rx_ok = 0;
  logic [2:0] ev_err_kind = 0;
  logic [7:0] tec, rec;
  logic       tx_warn, rx_warn, warn_any, err_passive, bus_off, err_dir;
  logic [4:0] err_flags;
  logic       warn_evt, passive_evt;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model state
  int m_tec = 0, m_rec = 0, m_flags = 0, m_dir = 0, m_bo = 0;
  int m_pw = 0, m_pp = 0, e_wevt = 0, e_pevt = 0;

  always #2 clk = ~clk;

  can_fault_tracker i_can_fault_tracker (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .load_en(load_en),
    .load_tec(load_tec), .load_rec(load_rec), .recover_req(recover_req),
    .ev_err(ev_err), .ev_err_kind(ev_err_kind), .ev_err_rx(ev_err_rx),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .tec(tec), .rec(rec),
    .tx_warn(tx_warn), .rx_warn(rx_warn), .warn_any(warn_any),
    .err_passive(err_passive), .bus_off(bus_off), .err_flags(err_flags),
    .err_dir(err_dir), .warn_evt(warn_evt), .passive_evt(passive_evt));

  function automatic int warn_of(int t, int r);
    return (t >= 96 || r >= 96) ? 1 : 0;
  endfunction
  function automatic int pass_of(int t, int r);
    return (t > 127 || r > 127) ? 1 : 0;
  endfunction
  function automatic int flags_of(int k);
    return (k < 5) ? (1 << k) : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R3 tec", tec, m_tec);
    chk("R2/R3 rec", rec, m_rec);
    chk("R4 tx_warn", tx_warn, (m_tec >= 96) ? 1 : 0);
    chk("R4 rx_warn", rx_warn, (m_rec >= 96) ? 1 : 0);
    chk("R4 warn_any", warn_any, warn_of(m_tec, m_rec));
    chk("R5 err_passive", err_passive, pass_of(m_tec, m_rec));
    chk("R6 warn_evt", warn_evt, e_wevt);
    chk("R7 passive_evt", passive_evt, e_pevt);
    chk("R8 err_flags", err_flags, m_flags);
    chk("R8 err_dir", err_dir, m_dir);
    chk("R9 bus_off", bus_off, m_bo);
  endtask

  // One clock: inputs set now (at a falling edge), model updated at the
  // rising edge, outputs compared at the next falling edge.
  task automatic step(input bit h, input bit le, input int lt, input int lr,
                      input bit rc, input bit e, input int k, input bit erx,
                      input bit tok, input bit rok);
    int acc, ow, op;
    hold_mode = h; load_en = le; load_tec = 8'(lt); load_rec = 8'(lr);
    recover_req = rc; ev_err = e; ev_err_kind = 3'(k); ev_err_rx = erx;
    ev_tx_ok = tok; ev_rx_ok = rok;
    @(posedge clk);
    acc = (!h && m_bo == 0) ? 1 : 0;
    ow = warn_of(m_tec, m_rec);
    op = pass_of(m_tec, m_rec);
    if (acc != 0 && e) begin
      m_flags = flags_of(k);
      m_dir = erx ? 1 : 0;
    end
    if (rc) begin
      m_tec = 0; m_rec = 0; m_bo = 0;
    end else if (h && le) begin
      m_tec = lt; m_rec = lr;
    end else if (acc != 0) begin
      if (e && !erx) begin
        if (m_tec + 8 > 255) begin m_tec = 255; m_bo = 1; end
        else m_tec = m_tec + 8;
      end else if (tok && m_tec > 0) m_tec--;
      if (e && erx) begin
        if (m_rec < 255) m_rec++;
      end else if (rok && m_rec > 0) m_rec--;
    end
    e_wevt = (warn_of(m_tec, m_rec) != ow) ? 1 : 0;
    e_pevt = (pass_of(m_tec, m_rec) != op) ? 1 : 0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_c0de);
    repeat (3) @(negedge clk);
    // R11: reset state
    compare_all();
    chk("R11 tec after reset", tec, 0);
    chk("R11 flags after reset", err_flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R3: success strobes at zero stay at zero
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R3 tec floor", tec, 0);
    chk("R3 rec floor", rec, 0);

    // R8: out-of-range kind, receive direction
    step(0, 0, 0, 0, 0, 1, 7, 1, 0, 0);
    chk("R8 kind 7 gives no flag", err_flags, 0);
    chk("R8 dir receive", err_dir, 1);
    // R8: stuff error on transmit, error beats success (R3)
    step(0, 0, 0, 0, 0, 1, 1, 0, 1, 0);
    chk("R8 stuff flag", err_flags, 5'b00010);
    chk("R3 error wins over success", tec, 8);
    idle();
    chk("R8 capture holds", err_flags, 5'b00010);

    // R10: events ignored in hold, then load
    step(1, 0, 0, 0, 0, 1, 4, 0, 0, 0);
    chk("R10 hold ignores error", tec, 8);
    chk("R10 hold keeps capture", err_flags, 5'b00010);
    step(1, 1, 100, 130, 0, 0, 0, 0, 0, 0);
    chk("R10 load tec", tec, 100);
    chk("R10 load rec", rec, 130);
    chk("R6 warn pulse on load", warn_evt, 1);
    chk("R7 passive pulse on load", passive_evt, 1);
    idle();
    chk("R6 pulse lasts one cycle", warn_evt, 0);
    // R7: leave passive via rx successes
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // R1/R9: drive to bus-off, events ignored, recover
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 33; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R1 saturated tec", tec, 255);
    chk("R9 bus_off set", bus_off, 1);
    step(0, 0, 0, 0, 0, 1, 3, 1, 1, 1);
    chk("R9 rx error ignored in bus-off", rec, 0);
    chk("R9 capture frozen in bus-off", err_flags, 5'b00001);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R9 recover clears", bus_off, 0);
    chk("R7 passive exit pulse", passive_evt, 1);

    // R2: receive saturation via load
    step(1, 1, 0, 254, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    chk("R2 rec saturates", rec, 255);

    // Constrained random phases: transmit-biased, then receive-biased
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 2500; n++) begin
        int r;
        bit h, le, rc, e, erx, tok, rok;
        r   = $urandom_range(0, 999);
        rc  = (r < 6);
        h   = (r >= 6 && r < 40);
        le  = h && ($urandom_range(0, 1) == 1);
        e   = ($urandom_range(0, 99) < 40);
        erx = (ph[0] == 1'b1) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 3);
        tok = ($urandom_range(0, 99) < 30);
        rok = ($urandom_range(0, 99) < ((ph[0] == 1'b1) ? 10 : 40));
        step(h, le, $urandom_range(0, 255), $urandom_range(60, 200), rc, e,
             $urandom_range(0, 7), erx, tok, rok);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule